// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation entries from a two-level table held in ordinary memory. A request carries the virtual address, a write flag and a user-mode flag. The walker starts at a root base address and reads one first-level (directory) entry. Depending on that entry, it either stops there with a 4 MiB mapping or reads one second-level (table) entry for a 4 KiB mapping. It returns the physical address together with the low twelve flag bits of the leaf entry. If the walk fails, it returns a fault with a three-bit cause code.

Each entry is 32 bits wide. Bits 31..12 hold a frame number and bits 11..0 hold flags. The flags the walker uses are: bit 0 valid, bit 1 writable, bit 2 user-accessible, bit 5 referenced, bit 6 modified, and bit 7 large-page (meaningful in a directory entry only). Bits 11..9 carry no meaning for the walker.

When a walk succeeds, the walker writes back entries whose referenced bit was clear, and sets the modified bit of the leaf on a write access. It does this with read-modify-write cycles on the same memory port. Only one walk is in flight at a time.

Top module: `pgwalk`

## Requirements
- R1: After reset, req_ready is 1 while rsp_valid and mem_req are 0. req_ready is 1 only when no walk is in progress. A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready stays 0 from then until one cycle after the response pulse.
- R2: The first memory access of every walk is a read (mem_we=0) at root_base + 4 × vaddr[31:22], using the root_base value present when the request is taken.
- R3: When the directory entry is valid (bit 0 = 1) and bit 7 is 0, the second read is at {dir[31:12], vaddr[21:12], 2'b00}.
- R4: When the directory entry is valid and bit 7 is 1, no second-level read is made. A successful result gives rsp_paddr = {dir[31:22], vaddr[21:0]} and rsp_flags = the directory entry's bits 11..0 after write-back.
- R5: A successful 4 KiB walk gives rsp_paddr = {tbl[31:12], vaddr[11:0]} and rsp_flags = the table entry's bits 11..0 after write-back, with rsp_fault = 0 and rsp_fault_code = 0.
- R6: A clear valid bit at either level gives rsp_fault = 1 and rsp_fault_code = {user, write, 0} (bit 2 user, bit 1 write, bit 0 = 0). rsp_paddr and rsp_flags are 0, and no memory write is made.
- R7: A user-mode access faults with rsp_fault_code = {user, write, 1} and makes no memory write in either of two cases: the effective user bit (bit 2) is 0, or the access is a write and the effective writable bit (bit 1) is 0. For a 4 KiB mapping each effective bit is the AND of both levels. For a 4 MiB mapping it is the directory entry's bit.
- R8: A supervisor access (user = 0) never raises a protection fault, whatever the writable and user bits of the entries hold.
- R9: Entry bits 11..9 affect neither the address nor the rights check. They are passed through unchanged in rsp_flags.
- R10: On success, every entry used whose bit 5 is 0 is rewritten with bit 5 set. On a write access the leaf entry also gets bit 6 set. The written word is the read word ORed with these bits. Entries that need no change are not written. The directory write precedes the table write.
- R11: Each accepted request produces exactly one rsp_valid pulse, lasting one cycle.
- R12: While mem_req is 1 and mem_ack is 0, mem_req, mem_we, mem_addr and mem_wdata hold their values. mem_ack ends the access in the cycle it is seen, and mem_rdata is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| root_base | input | 32 | Physical address of the directory page |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write data (0 on reads) |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_code | output | 3 | Cause: bit 0 protection, bit 1 write, bit 2 user |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_flags | output | 12 | Leaf entry flag bits after write-back |

## Verification
The bench targets the places where the two levels interact.

- A user write through a read-only directory entry that sits above a writable table entry has to fault. A design that takes rights from the leaf alone would let it through.
- A directory entry with bit 7 set must end the walk. A walker that ignored that bit would issue a stray second read, and the logged address would reveal it.
- Supervisor writes to read-only pages, and entries with bits 11..9 set, must leave the rights check alone. A design that checked rights for both modes would wrongly fault, and one that decoded the spare bits would show it in the fault code.
- Walks repeated over the same entries must write back only once, and the modified bit must go only to the leaf. Extra or missing writes in the logged memory traffic would expose errors in the write-back.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int unsigned FLAG_PRES  = 0;
  localparam int unsigned FLAG_WRITE = 1;
  localparam int unsigned FLAG_USER  = 2;
  localparam int unsigned FLAG_ACC   = 5;
  localparam int unsigned FLAG_DIRTY = 6;
  localparam int unsigned FLAG_BIG   = 7;

  localparam int unsigned FC_PROT = 0;
  localparam int unsigned FC_WR   = 1;
  localparam int unsigned FC_USR  = 2;
  localparam int unsigned FC_W    = 3;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_DIR = 3'd1,
    ST_RD_TBL = 3'd2,
    ST_WB_DIR = 3'd3,
    ST_WB_TBL = 3'd4,
    ST_RESP   = 3'd5
  } walk_state_e;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic                    sel_tbl,
  input  logic [VA_W-1:0]         root_base,
  input  logic [IDX_W-1:0]        dir_idx,
  input  logic [IDX_W-1:0]        tbl_idx,
  input  logic [VA_W-OFF_W-1:0]   tbl_frame,
  output logic [VA_W-1:0]         ent_addr
);
  localparam int unsigned SLOT_LG = OFF_W - IDX_W;
  localparam int unsigned PAD_W   = VA_W - OFF_W;

  logic [VA_W-1:0] dir_off;
  logic [VA_W-1:0] dir_addr;
  logic [VA_W-1:0] tbl_addr;

  // Directory slot: base plus index scaled by the entry size.
  assign dir_off  = {{PAD_W{1'b0}}, dir_idx, {SLOT_LG{1'b0}}};
  assign dir_addr = root_base + dir_off;
  // Table slot: frame of the table page joined with the scaled index.
  assign tbl_addr = {tbl_frame, tbl_idx, {SLOT_LG{1'b0}}};
  assign ent_addr = sel_tbl ? tbl_addr : dir_addr;

endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
  import pgwalk_pkg::*;
#(
  parameter int unsigned CODE_W = FC_W
) (
  input  logic              present,
  input  logic              is_user,
  input  logic              is_write,
  input  logic              user_ok,
  input  logic              write_ok,
  output logic              fault,
  output logic [CODE_W-1:0] code
);
  logic prot;

  // Supervisor accesses are never refused on rights.
  always_comb begin
    prot            = is_user && (!user_ok || (is_write && !write_ok));
    fault           = !present || prot;
    code            = '0;
    code[FC_PROT]   = present && prot;
    code[FC_WR]     = is_write;
    code[FC_USR]    = is_user;
  end

endmodule

// File: rtl/pgwalk_wb.sv
module pgwalk_wb
  import pgwalk_pkg::*;
#(
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] cur,
  input  logic             set_dirty,
  output logic [ENT_W-1:0] upd,
  output logic             need
);
  always_comb begin
    upd            = cur;
    upd[FLAG_ACC]  = 1'b1;
    if (set_dirty) upd[FLAG_DIRTY] = 1'b1;
  end

  assign need = (upd != cur);

endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [VA_W-1:0]   root_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [VA_W-1:0]   mem_addr,
  output logic [VA_W-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [VA_W-1:0]   mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [FC_W-1:0]   rsp_fault_code,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [OFF_W-1:0]  rsp_flags
);
  localparam int unsigned ENT_W       = VA_W;
  localparam int unsigned FRAME_W     = VA_W - OFF_W;
  localparam int unsigned BIG_OFF_W   = OFF_W + IDX_W;
  localparam int unsigned BIG_FRAME_W = VA_W - BIG_OFF_W;
  localparam int unsigned N_LVL       = 2;

  walk_state_e st_q, st_d;

  logic [VA_W-1:0]  va_q, base_q;
  logic [ENT_W-1:0] pde_q, pte_q;
  logic             wr_q, usr_q;

  logic             rsp_valid_q, rsp_fault_q;
  logic [FC_W-1:0]  rsp_code_q;
  logic [VA_W-1:0]  rsp_pa_q;
  logic [OFF_W-1:0] rsp_flags_q;

  logic in_rd_dir, in_rd_tbl, in_wb_dir, in_wb_tbl;
  assign in_rd_dir = (st_q == ST_RD_DIR);
  assign in_rd_tbl = (st_q == ST_RD_TBL);
  assign in_wb_dir = (st_q == ST_WB_DIR);
  assign in_wb_tbl = (st_q == ST_WB_TBL);

  // Entry sources: live read data in the read cycle, held copy afterwards.
  logic [ENT_W-1:0] dir_src, tbl_src;
  logic             dir_big;
  assign dir_src = in_rd_dir ? mem_rdata : pde_q;
  assign tbl_src = in_rd_tbl ? mem_rdata : pte_q;
  assign dir_big = dir_src[FLAG_BIG];

  // Write-back value per level.
  logic [ENT_W-1:0] wb_src   [N_LVL];
  logic [ENT_W-1:0] wb_upd   [N_LVL];
  logic             wb_dirty [N_LVL];
  logic             wb_need  [N_LVL];

  assign wb_src[0]   = dir_src;
  assign wb_dirty[0] = wr_q & dir_big;
  assign wb_src[1]   = tbl_src;
  assign wb_dirty[1] = wr_q;

  generate
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl_wb
      pgwalk_wb #(.ENT_W(ENT_W)) u_wb (
        .cur       (wb_src[g]),
        .set_dirty (wb_dirty[g]),
        .upd       (wb_upd[g]),
        .need      (wb_need[g])
      );
    end
  endgenerate

  // Rights check on the entry arriving now.
  logic            pr_uok, pr_wok, pr_fault;
  logic [FC_W-1:0] pr_code;
  assign pr_uok = in_rd_dir ? mem_rdata[FLAG_USER]
                            : (pde_q[FLAG_USER] & mem_rdata[FLAG_USER]);
  assign pr_wok = in_rd_dir ? mem_rdata[FLAG_WRITE]
                            : (pde_q[FLAG_WRITE] & mem_rdata[FLAG_WRITE]);

  pgwalk_perm #(.CODE_W(FC_W)) u_perm (
    .present  (mem_rdata[FLAG_PRES]),
    .is_user  (usr_q),
    .is_write (wr_q),
    .user_ok  (pr_uok),
    .write_ok (pr_wok),
    .fault    (pr_fault),
    .code     (pr_code)
  );

  // Entry address.
  logic [VA_W-1:0] ent_addr;
  pgwalk_addr #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .sel_tbl   (in_rd_tbl | in_wb_tbl),
    .root_base (base_q),
    .dir_idx   (va_q[VA_W-1 -: IDX_W]),
    .tbl_idx   (va_q[VA_W-IDX_W-1 -: IDX_W]),
    .tbl_frame (pde_q[VA_W-1 -: FRAME_W]),
    .ent_addr  (ent_addr)
  );

  assign mem_req   = in_rd_dir | in_rd_tbl | in_wb_dir | in_wb_tbl;
  assign mem_we    = in_wb_dir | in_wb_tbl;
  assign mem_addr  = ent_addr;
  assign mem_wdata = in_wb_tbl ? wb_upd[1] : (in_wb_dir ? wb_upd[0] : '0);

  // Successful result, valid whenever the leaf source is settled.
  logic [VA_W-1:0]  ok_pa;
  logic [OFF_W-1:0] ok_flags;
  assign ok_pa    = dir_big ? {dir_src[VA_W-1 -: BIG_FRAME_W], va_q[BIG_OFF_W-1:0]}
                            : {tbl_src[VA_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
  assign ok_flags = dir_big ? wb_upd[0][OFF_W-1:0] : wb_upd[1][OFF_W-1:0];

  logic go_resp, go_fault, dir_stop;
  assign dir_stop = !mem_rdata[FLAG_PRES] || mem_rdata[FLAG_BIG];

  always_comb begin
    st_d     = st_q;
    go_resp  = 1'b0;
    go_fault = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_ack) begin
        if (dir_stop) begin
          if (pr_fault)        begin go_resp = 1'b1; go_fault = 1'b1; end
          else if (wb_need[0]) st_d = ST_WB_DIR;
          else                 go_resp = 1'b1;
        end else begin
          st_d = ST_RD_TBL;
        end
      end
      ST_RD_TBL: if (mem_ack) begin
        if (pr_fault)          begin go_resp = 1'b1; go_fault = 1'b1; end
        else if (wb_need[0])   st_d = ST_WB_DIR;
        else if (wb_need[1])   st_d = ST_WB_TBL;
        else                   go_resp = 1'b1;
      end
      ST_WB_DIR: if (mem_ack) begin
        if (!dir_big && wb_need[1]) st_d = ST_WB_TBL;
        else                        go_resp = 1'b1;
      end
      ST_WB_TBL: if (mem_ack) go_resp = 1'b1;
      ST_RESP:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
    if (go_resp) st_d = ST_RESP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      pde_q       <= '0;
      pte_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_pa_q    <= '0;
      rsp_flags_q <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= go_resp;
      if (st_q == ST_IDLE && req_valid) begin
        va_q   <= req_vaddr;
        base_q <= root_base;
        wr_q   <= req_write;
        usr_q  <= req_user;
      end
      if (in_rd_dir && mem_ack) pde_q <= mem_rdata;
      if (in_rd_tbl && mem_ack) pte_q <= mem_rdata;
      if (go_resp) begin
        rsp_fault_q <= go_fault;
        rsp_code_q  <= go_fault ? pr_code : '0;
        rsp_pa_q    <= go_fault ? '0 : ok_pa;
        rsp_flags_q <= go_fault ? '0 : ok_flags;
      end
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign rsp_valid      = rsp_valid_q;
  assign rsp_fault      = rsp_fault_q;
  assign rsp_fault_code = rsp_code_q;
  assign rsp_paddr      = rsp_pa_q;
  assign rsp_flags      = rsp_flags_q;

  // R1: once a request is taken the walker stops accepting.
  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11: the response strobe lasts a single cycle.
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R12: a pending memory access keeps its command stable.
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8: a protection cause is only ever reported for user accesses.
  p_prot_user_only_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault_code[FC_PROT]) |-> rsp_fault_code[FC_USR]);

  // R6: a faulting response carries no address or flags.
  p_fault_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_flags == '0));

  // R10: a successful leaf always reports the referenced bit set.
  p_leaf_ref_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_flags[FLAG_ACC]);

  // R10: writes never happen while the response for a fault is forming.
  p_no_write_in_resp_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req);

endmodule

// File: tb/pgwalk_test.sv
`timescale 1ns/1ps
module pgwalk_test;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user  = 1'b0;
  logic [31:0] root_base = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_fault_code;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_flags;

  always #(CLK_NS/2) clk = ~clk;

  pgwalk uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .root_base(root_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_fault_code(rsp_fault_code), .rsp_paddr(rsp_paddr),
    .rsp_flags(rsp_flags)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  bit busy = 0;
  int rsp_cnt = 0;
  int lat = 1;
  int ack_cnt = 0;

  logic [31:0] memimg [logic [31:0]];
  logic [31:0] rlog[$];
  logic [31:0] wlog_a[$];
  logic [31:0] wlog_d[$];

  function automatic logic [31:0] rd(logic [31:0] a);
    return memimg.exists(a) ? memimg[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory responder with configurable wait cycles.
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      ack_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      ack_cnt <= 0;
    end else if (mem_req) begin
      if (ack_cnt >= lat) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          memimg[mem_addr] = mem_wdata;
          wlog_a.push_back(mem_addr);
          wlog_d.push_back(mem_wdata);
        end else begin
          mem_rdata <= rd(mem_addr);
          rlog.push_back(mem_addr);
        end
      end else begin
        ack_cnt <= ack_cnt + 1;
      end
    end
  end

  // Per-cycle comparison of the handshake against the model's busy state.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(req_ready === !busy, "R1", "req_ready vs model", {31'b0, req_ready}, {31'b0, !busy});
      if (rsp_valid) begin
        chk(busy, "R11", "response without request", 32'd1, 32'd0);
        rsp_cnt++;
        busy = 0;
      end
    end
  end

  task automatic walk(logic [31:0] va, bit w, bit u, string rq);
    logic [31:0] pde, pte, pde_a, pte_a, nv;
    logic [31:0] pa_e;
    logic [11:0] fl_e;
    logic [2:0]  code_e;
    bit f_e, prot, ue, we;
    logic [31:0] er[$];
    logic [31:0] ewa[$];
    logic [31:0] ewd[$];
    int waited;
    pa_e = 0; fl_e = 0; code_e = 0; f_e = 0; prot = 0;
    pde_a = root_base + {20'b0, va[31:22], 2'b00};
    pde = rd(pde_a);
    er.push_back(pde_a);
    if (!pde[0]) f_e = 1;
    else if (pde[7]) begin
      prot = u && (!pde[2] || (w && !pde[1]));
      if (prot) f_e = 1;
      else begin
        nv = pde | 32'h20 | (w ? 32'h40 : 32'h0);
        if (nv != pde) begin ewa.push_back(pde_a); ewd.push_back(nv); end
        pa_e = {pde[31:22], va[21:0]};
        fl_e = nv[11:0];
      end
    end else begin
      pte_a = {pde[31:12], va[21:12], 2'b00};
      er.push_back(pte_a);
      pte = rd(pte_a);
      if (!pte[0]) f_e = 1;
      else begin
        ue = pde[2] & pte[2];
        we = pde[1] & pte[1];
        prot = u && (!ue || (w && !we));
        if (prot) f_e = 1;
        else begin
          if (!pde[5]) begin ewa.push_back(pde_a); ewd.push_back(pde | 32'h20); end
          nv = pte | 32'h20 | (w ? 32'h40 : 32'h0);
          if (nv != pte) begin ewa.push_back(pte_a); ewd.push_back(nv); end
          pa_e = {pte[31:12], va[11:0]};
          fl_e = nv[11:0];
        end
      end
    end
    if (f_e) code_e = {u, w, prot};

    rlog.delete(); wlog_a.delete(); wlog_d.delete();
    rsp_cnt = 0;
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    busy = 1;
    waited = 0;
    while (rsp_valid !== 1'b1 && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 400) begin
      chk(0, "R11", "no response", 32'd0, 32'd1);
      return;
    end
    chk(rsp_fault === f_e, rq, "fault flag", {31'b0, rsp_fault}, {31'b0, f_e});
    chk(rsp_fault_code === code_e, f_e ? (prot ? "R7" : "R6") : rq, "fault code",
        {29'b0, rsp_fault_code}, {29'b0, code_e});
    chk(rsp_paddr === pa_e, rq, "physical address", rsp_paddr, pa_e);
    chk(rsp_flags === fl_e, rq, "leaf flags", {20'b0, rsp_flags}, {20'b0, fl_e});
    @(negedge clk);
    chk(rsp_cnt == 1, "R11", "response pulses", rsp_cnt, 32'd1);
    chk(rlog.size() == er.size(), er.size() == 1 ? "R4" : "R3", "read count",
        rlog.size(), er.size());
    foreach (er[i]) if (i < rlog.size())
      chk(rlog[i] === er[i], i == 0 ? "R2" : "R3", "read address", rlog[i], er[i]);
    chk(wlog_a.size() == ewa.size(), "R10", "write count", wlog_a.size(), ewa.size());
    foreach (ewa[i]) if (i < wlog_a.size()) begin
      chk(wlog_a[i] === ewa[i], "R10", "write address", wlog_a[i], ewa[i]);
      chk(wlog_d[i] === ewd[i], "R10", "write data", wlog_d[i], ewd[i]);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rb;
    root_base = 32'h0010_0000;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "reset ready", {31'b0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R1", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk(mem_req === 1'b0, "R1", "reset mem_req", {31'b0, mem_req}, 32'd0);

    // Directed image.
    memimg[32'h0010_0004] = 32'h0020_0007;
    memimg[32'h0020_0008] = 32'h0ABC_D007;
    memimg[32'h0020_0014] = 32'h0111_1003;
    memimg[32'h0010_000C] = 32'h0C40_0087;
    memimg[32'h0010_0018] = 32'h0030_0005;
    memimg[32'h0030_0000] = 32'h0222_2007;
    memimg[32'h0010_001C] = 32'h0040_0E05;
    memimg[32'h0040_0000] = 32'h0333_3E07;
    memimg[32'h0010_0020] = 32'h0800_0083;

    walk({10'd1, 10'd2, 12'h345}, 0, 0, "R5");   // both A written
    walk({10'd1, 10'd2, 12'h346}, 0, 1, "R10");  // no writes now
    walk({10'd1, 10'd2, 12'h000}, 1, 1, "R10");  // dirty on leaf only
    walk({10'd3, 22'h012345}, 1, 1, "R4");       // large page
    walk({10'd3, 22'h3FFFFF}, 0, 0, "R4");
    walk({10'd5, 10'd0, 12'h0}, 1, 1, "R6");     // directory missing
    walk({10'd1, 10'd4, 12'h0}, 0, 0, "R6");     // table entry missing
    walk({10'd1, 10'd5, 12'h10}, 0, 1, "R7");    // user bit clear in leaf
    walk({10'd6, 10'd0, 12'h20}, 1, 1, "R7");    // directory read-only
    walk({10'd6, 10'd0, 12'h24}, 0, 1, "R7");    // user read allowed
    walk({10'd6, 10'd0, 12'h28}, 1, 0, "R8");    // supervisor write, ro
    walk({10'd1, 10'd5, 12'h30}, 1, 0, "R8");    // supervisor, user clear
    walk({10'd7, 10'd0, 12'h40}, 1, 1, "R9");    // spare bits grant nothing
    walk({10'd7, 10'd0, 12'h44}, 0, 1, "R9");    // spare bits passed through
    walk({10'd8, 22'h0}, 0, 1, "R7");            // large page, user clear

    // Unaligned base still adds the scaled index.
    root_base = 32'h0050_0010;
    memimg[32'h0050_0014] = 32'h0020_0027;
    walk({10'd1, 10'd2, 12'hABC}, 0, 0, "R2");

    // Randomised walks with varying memory wait.
    rb = 32'h0060_0000;
    root_base = rb;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 0)       memimg[rb + i*4] = {r[31:22], 22'h0} | (r & 32'hE66) | 32'h81;
      else if (r[4:3] == 0)  memimg[rb + i*4] = (32'h0070_0000 + i*32'h1000) | (r & 32'hE66);
      else                   memimg[rb + i*4] = (32'h0070_0000 + i*32'h1000) | (r & 32'hE66) | 32'h1;
      for (int j = 0; j < 8; j++) begin
        logic [31:0] s;
        s = $urandom;
        memimg[32'h0070_0000 + i*32'h1000 + j*4] = (s & 32'hFFFF_FFFE) | {31'b0, s[3:0] != 0};
      end
    end
    for (int k = 0; k < 120; k++) begin
      logic [31:0] r;
      r = $urandom;
      lat = r[9:8];
      walk({5'd0, r[2:0] > 4 ? 5'd4 : {3'b0, r[1:0]}, 7'd0, r[6:4], 12'(r[31:20])},
           r[12], r[13], "R5");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule